// File: doc/BRIEF.md
# Transfer Length and Terminal-Count Controller

This block keeps the byte counter that governs each DMA information-transfer step of a bus-attached storage controller. The host writes a two-byte count into a shadow register; that value becomes visible in the live (readable) counter only when a command carrying the DMA flag arrives. A transfer command issued in DMA mode starts a step whose length is the smaller of the programmed count and the amount the target still expects to move. A count of zero stands for 65536 bytes. While command bytes are being captured, the cap is 32 bytes instead of the target's residual.

During a step the target side offers data in chunks. Each chunk consumes part of the step length and moves a private copy of the signed residual toward zero. The step ends in one of three ways. It ends at once when the DMA length runs out inside a chunk. It also ends at once when an into-memory transfer uses up its length while the target still holds data. Otherwise completion waits for the next chunk offer or for the target's finish signal. Completion sets terminal count, zeroes the live counter and emits a one-clock done pulse.

Top module: `xfer_count_ctl`

## Requirements
- R1: After reset, live_count is 0, tc_flag, dma_mode, step_busy and step_done are 0, and dma_len is 0.
- R2: A pulse on cnt_wr[0] writes wr_data into the low byte of the shadow count, and a pulse on cnt_wr[1] writes the middle byte. Such a write leaves live_count unchanged and clears tc_flag on the next clock.
- R3: A command (cmd_valid) with cmd_dma=1 copies the shadow count, as it stood before that clock, into live_count and sets dma_mode. With cmd_dma=0 it clears dma_mode and leaves live_count alone.
- R4: A command with cmd_dma=1 and cmd_xfer=1 starts a step: step_busy goes to 1, tc_flag to 0, and dma_len becomes min(N, |resid|). N is the shadow count, with 0 read as 65536. resid is signed and a negative value means toward the device.
- R5: With capture_mode=1, the step length is min(N, 32) whatever the residual.
- R6: A transfer command with cmd_dma=0 starts no step.
- R7: When a chunk offer (chunk_valid with chunk_bytes>0) is larger than the remaining step length, the step completes at that clock.
- R8: For an into-memory step (resid>0 at start), a chunk that brings the remaining length to 0 completes the step at once if the residual is still above 0. If the residual is 0, completion waits.
- R9: For a toward-device step, a fully consumed chunk defers completion. A later chunk offer made with no length left completes the step when the residual is at most 0.
- R10: Completion sets tc_flag, zeroes live_count, clears step_busy, and drives step_done high for exactly one clock.
- R11: A command with cmd_dma=1 issued during a step aborts that step without a step_done pulse.
- R12: target_fin completes an active step and is ignored when no step is active.
- R13: In one clock, completion wins over a count write's clear of tc_flag. A command wins over a chunk offer, and the chunk is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 2 | Byte write strobes for the shadow count: bit 0 low byte, bit 1 middle byte |
| wr_data | input | BYTE_W | Byte written to the shadow count |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| cmd_xfer | input | 1 | Command is an information-transfer command |
| capture_mode | input | 1 | Command bytes are being captured (32-byte cap) |
| resid | input | RES_W | Signed residual the target expects, sampled at step start |
| chunk_valid | input | 1 | Target offers a chunk |
| chunk_bytes | input | 2*BYTE_W+1 | Size of the offered chunk |
| target_fin | input | 1 | Target has finished the command |
| dma_len | output | 2*BYTE_W+1 | Length of the current or last step |
| live_count | output | 2*BYTE_W | Readable live count |
| tc_flag | output | 1 | Terminal-count status |
| dma_mode | output | 1 | DMA mode from the last command |
| step_busy | output | 1 | A DMA step is active |
| step_done | output | 1 | One-clock completion pulse |

## Verification
The hardest condition to reach is the deferred completion of a toward-device step. The length must be used up by a chunk that exactly fits, so that no partial-chunk completion happens. A second chunk offer must then arrive while no length is left. The stimulus sets a residual equal in magnitude to the step length and offers an exact-size chunk, then a small extra chunk. It runs the same exact-fit pattern on an into-memory step, once with the target still holding data and once with it drained, to separate immediate from deferred completion.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;

  // Reason a step ended, used inside the step controller
  typedef enum logic [1:0] {
    FIN_NONE    = 2'd0,
    FIN_PARTIAL = 2'd1,
    FIN_DRAINED = 2'd2,
    FIN_TARGET  = 2'd3
  } fin_cause_e;

endpackage

// File: rtl/xfer_count_regs.sv
module xfer_count_regs #(
  parameter int BYTE_W = 8,
  parameter int NLANE  = 2,
  localparam int CNT_W = NLANE * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLANE-1:0]  lane_we,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load_live,
  input  logic              clear_live,
  output logic [CNT_W-1:0]  shadow_cnt,
  output logic [CNT_W-1:0]  live_cnt
);

  logic [CNT_W-1:0] live_q;
  logic [CNT_W-1:0] live_d;
  logic             live_en;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (lane_we[g]) begin
        byte_q <= wr_data;
      end
    end
    assign shadow_cnt[g*BYTE_W +: BYTE_W] = byte_q;
  end

  always_comb begin
    live_en = load_live | clear_live;
    live_d  = load_live ? shadow_cnt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (live_en) begin
      live_q <= live_d;
    end
  end

  assign live_cnt = live_q;

endmodule

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
  parameter int CNT_W     = 16,
  parameter int RES_W     = 20,
  parameter int CAP_BYTES = 32,
  localparam int LEN_W    = CNT_W + 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic [RES_W-1:0] resid,
  input  logic             capture,
  output logic [LEN_W-1:0] step_len
);

  logic [LEN_W-1:0] eff_len;
  logic [RES_W-1:0] mag;
  logic [RES_W-1:0] eff_wide;
  logic [LEN_W-1:0] cap_len;

  always_comb begin
    eff_len  = (count == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count};
    mag      = resid[RES_W-1] ? (~resid + 1'b1) : resid;
    eff_wide = {{(RES_W-LEN_W){1'b0}}, eff_len};
    cap_len  = LEN_W'(CAP_BYTES);
    if (capture) begin
      step_len = (eff_len < cap_len) ? eff_len : cap_len;
    end else if (mag > eff_wide) begin
      step_len = eff_len;
    end else begin
      step_len = mag[LEN_W-1:0];
    end
  end

endmodule

// File: rtl/xfer_step_ctrl.sv
module xfer_step_ctrl
  import xfer_count_pkg::*;
#(
  parameter int LEN_W = 17,
  parameter int RES_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_wr,
  input  logic             cmd_valid,
  input  logic             cmd_dma,
  input  logic             cmd_xfer,
  input  logic [LEN_W-1:0] step_len,
  input  logic [RES_W-1:0] resid,
  input  logic             chunk_valid,
  input  logic [LEN_W-1:0] chunk_bytes,
  input  logic             target_fin,
  output logic             fin_now,
  output logic [LEN_W-1:0] dma_len,
  output logic             tc_flag,
  output logic             dma_mode,
  output logic             step_busy,
  output logic             step_done
);

  logic             busy_q, busy_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             todev_q, todev_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             mode_q, mode_d;
  logic             tc_q, tc_d;
  logic             done_q;
  fin_cause_e       cause;

  logic [LEN_W-1:0] moved;
  logic [LEN_W-1:0] rem_after;
  logic [RES_W-1:0] moved_wide;
  logic [RES_W-1:0] res_after;
  logic             res_after_pos;
  logic             res_nonpos;
  logic             chunk_ok;

  always_comb begin
    moved         = (rem_q < chunk_bytes) ? rem_q : chunk_bytes;
    rem_after     = rem_q - moved;
    moved_wide    = {{(RES_W-LEN_W){1'b0}}, moved};
    res_after     = todev_q ? (res_q + moved_wide) : (res_q - moved_wide);
    res_after_pos = !res_after[RES_W-1] && (res_after != '0);
    res_nonpos    = res_q[RES_W-1] || (res_q == '0);
    chunk_ok      = chunk_valid && (chunk_bytes != '0);
  end

  always_comb begin
    busy_d  = busy_q;
    rem_d   = rem_q;
    res_d   = res_q;
    todev_d = todev_q;
    len_d   = len_q;
    mode_d  = mode_q;
    tc_d    = tc_q;
    cause   = FIN_NONE;
    if (any_wr) begin
      tc_d = 1'b0;
    end
    if (cmd_valid) begin
      mode_d = cmd_dma;
      if (cmd_dma) begin
        busy_d = 1'b0;
      end
      if (cmd_dma && cmd_xfer) begin
        busy_d  = 1'b1;
        rem_d   = step_len;
        res_d   = resid;
        todev_d = resid[RES_W-1];
        len_d   = step_len;
        tc_d    = 1'b0;
      end
    end else if (busy_q) begin
      if (target_fin) begin
        cause = FIN_TARGET;
      end else if (chunk_ok) begin
        if (rem_q == '0) begin
          if (res_nonpos) begin
            cause = FIN_TARGET;
          end
        end else begin
          rem_d = rem_after;
          res_d = res_after;
          if (moved < chunk_bytes) begin
            cause = FIN_PARTIAL;
          end else if (!todev_q && (rem_after == '0) && res_after_pos) begin
            cause = FIN_DRAINED;
          end
        end
      end
      if (cause != FIN_NONE) begin
        busy_d = 1'b0;
        tc_d   = 1'b1;
      end
    end
  end

  assign fin_now = (cause != FIN_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rem_q   <= '0;
      res_q   <= '0;
      todev_q <= 1'b0;
      len_q   <= '0;
      mode_q  <= 1'b0;
      tc_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      rem_q   <= rem_d;
      res_q   <= res_d;
      todev_q <= todev_d;
      len_q   <= len_d;
      mode_q  <= mode_d;
      tc_q    <= tc_d;
      done_q  <= fin_now;
    end
  end

  assign dma_len   = len_q;
  assign tc_flag   = tc_q;
  assign dma_mode  = mode_q;
  assign step_busy = busy_q;
  assign step_done = done_q;

endmodule

// File: rtl/xfer_count_ctl.sv
module xfer_count_ctl #(
  parameter int BYTE_W    = 8,
  parameter int RES_W     = 20,
  parameter int CAP_BYTES = 32,
  localparam int CNT_W    = 2 * BYTE_W,
  localparam int LEN_W    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cnt_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic              cmd_dma,
  input  logic              cmd_xfer,
  input  logic              capture_mode,
  input  logic [RES_W-1:0]  resid,
  input  logic              chunk_valid,
  input  logic [LEN_W-1:0]  chunk_bytes,
  input  logic              target_fin,
  output logic [LEN_W-1:0]  dma_len,
  output logic [CNT_W-1:0]  live_count,
  output logic              tc_flag,
  output logic              dma_mode,
  output logic              step_busy,
  output logic              step_done
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] shadow_cnt;
  logic [LEN_W-1:0] step_len;
  logic             fin_now;
  logic             load_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign load_live = cmd_valid && cmd_dma;

  xfer_count_regs #(.BYTE_W(BYTE_W), .NLANE(2)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lane_we    (cnt_wr),
    .wr_data    (wr_data),
    .load_live  (load_live),
    .clear_live (fin_now),
    .shadow_cnt (shadow_cnt),
    .live_cnt   (live_count)
  );

  xfer_len_calc #(.CNT_W(CNT_W), .RES_W(RES_W), .CAP_BYTES(CAP_BYTES)) u_len (
    .count    (shadow_cnt),
    .resid    (resid),
    .capture  (capture_mode),
    .step_len (step_len)
  );

  xfer_step_ctrl #(.LEN_W(LEN_W), .RES_W(RES_W)) u_step (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .any_wr      (|cnt_wr),
    .cmd_valid   (cmd_valid),
    .cmd_dma     (cmd_dma),
    .cmd_xfer    (cmd_xfer),
    .step_len    (step_len),
    .resid       (resid),
    .chunk_valid (chunk_valid),
    .chunk_bytes (chunk_bytes),
    .target_fin  (target_fin),
    .fin_now     (fin_now),
    .dma_len     (dma_len),
    .tc_flag     (tc_flag),
    .dma_mode    (dma_mode),
    .step_busy   (step_busy),
    .step_done   (step_done)
  );

endmodule

// File: rtl/xfer_count_ctl_chk.sv
module xfer_count_ctl_chk #(
  parameter int BYTE_W    = 8,
  parameter int CAP_BYTES = 32,
  localparam int CNT_W    = 2 * BYTE_W,
  localparam int LEN_W    = CNT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cnt_wr,
  input logic             cmd_valid,
  input logic             cmd_dma,
  input logic             cmd_xfer,
  input logic             capture_mode,
  input logic [CNT_W-1:0] shadow_cnt,
  input logic [LEN_W-1:0] dma_len,
  input logic [CNT_W-1:0] live_count,
  input logic             tc_flag,
  input logic             dma_mode,
  input logic             step_busy,
  input logic             step_done
);

  AST_SHADOW_TO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_dma |=> live_count == $past(shadow_cnt)); // R3

  AST_MODE_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> dma_mode == $past(cmd_dma)); // R3

  AST_WRITE_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr != 2'b00) |=> (!tc_flag || step_done)); // R2

  AST_START_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_dma && cmd_xfer |=> step_busy && !tc_flag); // R4

  AST_CAPTURE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_dma && cmd_xfer && capture_mode |=> dma_len <= LEN_W'(CAP_BYTES)); // R5

  AST_NO_PIO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_dma && !step_busy |=> !step_busy); // R6

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done); // R10

  AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> tc_flag && !step_busy && live_count == '0); // R10

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_dma |=> !step_done); // R11

  AST_DONE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step_busy |=> !step_done); // R12

endmodule

bind xfer_count_ctl xfer_count_ctl_chk #(.BYTE_W(BYTE_W), .CAP_BYTES(CAP_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_wr       (cnt_wr),
  .cmd_valid    (cmd_valid),
  .cmd_dma      (cmd_dma),
  .cmd_xfer     (cmd_xfer),
  .capture_mode (capture_mode),
  .shadow_cnt   (shadow_cnt),
  .dma_len      (dma_len),
  .live_count   (live_count),
  .tc_flag      (tc_flag),
  .dma_mode     (dma_mode),
  .step_busy    (step_busy),
  .step_done    (step_done)
);

// File: tb/tb_xfer_count_ctl.sv
module tb_xfer_count_ctl;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 20;
  localparam int CAP    = 32;
  localparam int CNT_W  = 16;
  localparam int LEN_W  = 17;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [1:0]        cnt_wr;
  logic [BYTE_W-1:0] wr_data;
  logic              cmd_valid, cmd_dma, cmd_xfer, capture_mode;
  logic [RES_W-1:0]  resid;
  logic              chunk_valid;
  logic [LEN_W-1:0]  chunk_bytes;
  logic              target_fin;
  logic [LEN_W-1:0]  dma_len;
  logic [CNT_W-1:0]  live_count;
  logic              tc_flag, dma_mode, step_busy, step_done;

  xfer_count_ctl #(.BYTE_W(BYTE_W), .RES_W(RES_W), .CAP_BYTES(CAP)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer),
    .capture_mode(capture_mode), .resid(resid), .chunk_valid(chunk_valid),
    .chunk_bytes(chunk_bytes), .target_fin(target_fin), .dma_len(dma_len),
    .live_count(live_count), .tc_flag(tc_flag), .dma_mode(dma_mode),
    .step_busy(step_busy), .step_done(step_done)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // Behavioural reference state
  int m_sh, m_live, m_len, m_rem, m_res;
  bit m_mode, m_tc, m_busy, m_todev, m_done;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_update();
    int old_sh, eff, mag, r, mv, cb;
    bit fin;
    old_sh = m_sh;
    fin    = 0;
    r      = int'(signed'(resid));
    cb     = int'(chunk_bytes);
    if (cnt_wr[0]) m_sh = (m_sh & 32'hFF00) | int'(wr_data);
    if (cnt_wr[1]) m_sh = (m_sh & 32'h00FF) | (int'(wr_data) << 8);
    if (cnt_wr != 2'b00) m_tc = 0;
    if (cmd_valid) begin
      m_mode = cmd_dma;
      if (cmd_dma) begin
        m_live = old_sh;
        m_busy = 0;
      end
      if (cmd_dma && cmd_xfer) begin
        eff     = (old_sh == 0) ? 65536 : old_sh;
        mag     = (r < 0) ? -r : r;
        m_len   = capture_mode ? imin(eff, CAP) : imin(eff, mag);
        m_rem   = m_len;
        m_res   = r;
        m_todev = (r < 0);
        m_busy  = 1;
        m_tc    = 0;
      end
    end else if (m_busy) begin
      if (target_fin) fin = 1;
      else if (chunk_valid && cb != 0) begin
        if (m_rem == 0) begin
          if (m_res <= 0) fin = 1;
        end else begin
          mv    = imin(m_rem, cb);
          m_rem = m_rem - mv;
          m_res = m_todev ? m_res + mv : m_res - mv;
          if (mv < cb) fin = 1;
          else if (!m_todev && m_rem == 0 && m_res > 0) fin = 1;
        end
      end
      if (fin) begin
        m_busy = 0;
        m_tc   = 1;
        m_live = 0;
      end
    end
    m_done = fin;
  endtask

  task automatic compare_all();
    check(tag, "dma_len",    int'(dma_len),    m_len);
    check(tag, "live_count", int'(live_count), m_live);
    check(tag, "tc_flag",    int'(tc_flag),    int'(m_tc));
    check(tag, "dma_mode",   int'(dma_mode),   int'(m_mode));
    check(tag, "step_busy",  int'(step_busy),  int'(m_busy));
    check(tag, "step_done",  int'(step_done),  int'(m_done));
  endtask

  task automatic clear_inputs();
    cnt_wr = 2'b00; wr_data = '0; cmd_valid = 0; cmd_dma = 0; cmd_xfer = 0;
    capture_mode = 0; resid = '0; chunk_valid = 0; chunk_bytes = '0; target_fin = 0;
  endtask

  // Called at a falling edge; inputs held through the next rising edge
  task automatic tick();
    @(posedge clk);
    model_update();
    #2;
    compare_all();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic wr(int lane, int v);
    cnt_wr[lane] = 1'b1; wr_data = BYTE_W'(v); tick();
  endtask

  task automatic cmd(bit dma, bit xfer, bit cap, int r);
    cmd_valid = 1; cmd_dma = dma; cmd_xfer = xfer; capture_mode = cap;
    resid = RES_W'(r); tick();
  endtask

  task automatic chunk(int n);
    chunk_valid = 1; chunk_bytes = LEN_W'(n); tick();
  endtask

  task automatic tfin();
    target_fin = 1; tick();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    m_sh = 0; m_live = 0; m_len = 0; m_rem = 0; m_res = 0;
    m_mode = 0; m_tc = 0; m_busy = 0; m_todev = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    tag = "R1"; compare_all();
    check("R1", "reset live_count", int'(live_count), 0);
    check("R1", "reset tc_flag", int'(tc_flag), 0);

    tag = "R2";
    wr(0, 'h34); wr(1, 'h12);
    check("R2", "live untouched by shadow write", int'(live_count), 0);

    tag = "R3";
    cmd(1, 0, 0, 0);
    check("R3", "live loaded from shadow", int'(live_count), 'h1234);
    check("R3", "dma mode set", int'(dma_mode), 1);
    cmd(0, 0, 0, 0);
    check("R3", "dma mode cleared", int'(dma_mode), 0);
    check("R3", "live kept", int'(live_count), 'h1234);

    tag = "R4";
    cmd(1, 1, 0, 100);
    check("R4", "len = residual", int'(dma_len), 100);
    check("R4", "busy", int'(step_busy), 1);
    tag = "R8";
    chunk(40);
    chunk(60);
    check("R8", "drained target defers", int'(step_done), 0);
    tag = "R12";
    tfin();
    check("R12", "target finish completes", int'(step_done), 1);
    check("R10", "tc set", int'(tc_flag), 1);
    check("R10", "live zeroed", int'(live_count), 0);
    tag = "R10";
    tick();
    check("R10", "done lasts one clock", int'(step_done), 0);

    tag = "R2";
    wr(0, 'h10);
    check("R2", "write clears tc", int'(tc_flag), 0);
    wr(1, 0);
    tag = "R8";
    cmd(1, 1, 0, 100);
    check("R8", "len = count 16", int'(dma_len), 16);
    chunk(16);
    check("R8", "immediate completion with data left", int'(step_done), 1);

    tag = "R7";
    wr(0, 8);
    cmd(1, 1, 0, 50);
    chunk(20);
    check("R7", "partial chunk completes", int'(step_done), 1);

    tag = "R4";
    wr(0, 0);
    cmd(1, 1, 0, 100000);
    check("R4", "zero count means 65536", int'(dma_len), 65536);
    tag = "R11";
    cmd(1, 0, 0, 0);
    check("R11", "abort no done", int'(step_done), 0);
    check("R11", "abort clears busy", int'(step_busy), 0);

    tag = "R9";
    cmd(1, 1, 0, -30);
    check("R9", "toward-device len", int'(dma_len), 30);
    chunk(30);
    check("R9", "exact chunk defers", int'(step_done), 0);
    check("R9", "still busy", int'(step_busy), 1);
    chunk(5);
    check("R9", "deferred completion", int'(step_done), 1);

    tag = "R5";
    wr(1, 1);
    cmd(1, 1, 1, 0);
    check("R5", "capture cap 32", int'(dma_len), 32);
    tfin();

    tag = "R6";
    cmd(0, 1, 0, 10);
    check("R6", "no step without dma", int'(step_busy), 0);

    tag = "R12";
    tfin();
    check("R12", "finish ignored when idle", int'(step_done), 0);
    check("R12", "tc unchanged when idle", int'(tc_flag), 1);

    tag = "R13";
    wr(0, 'h10); wr(1, 0);
    cmd(1, 1, 0, 100);
    chunk_valid = 1; chunk_bytes = LEN_W'(16); cnt_wr = 2'b01; wr_data = 8'h20;
    tick();
    check("R13", "completion beats write clear", int'(tc_flag), 1);
    cmd(1, 1, 0, 100);
    check("R13", "len from new shadow", int'(dma_len), 32);
    cmd_valid = 1; cmd_dma = 1; chunk_valid = 1; chunk_bytes = LEN_W'(64);
    tick();
    check("R13", "command beats chunk", int'(step_done), 0);
    check("R13", "step aborted", int'(step_busy), 0);
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule